// File: doc/BRIEF.md
# Software-Filled Translation Lookaside Buffer with Address-Space Tags

This block is a small, fully associative cache of page translations. The hardware only searches it, and software alone fills it. A lookup presents a virtual page number, the current 6-bit address-space tag and a store/load flag. One cycle later the block reports one of four outcomes: a granted translation with its frame number and noncacheable attribute, a refill miss, an invalid-entry exception or a modify exception. A page-table miss is only reported; the block never fetches entries itself.

Software writes entries in one of two ways. The first kind of write goes to the slot held in an index register. The second goes to the slot named by a free-running random counter. The random counter skips the lowest slots, which software reserves by setting a locked-slot count. A probe command searches for a page and tag without translating. On a match it loads the index register with the matching slot; on a failed search it raises a not-found flag. When several entries match, the lowest-numbered slot is used and a flag reports the overlap.

Top module: `sw_tlb`

## Requirements
- R1: A lookup request is answered exactly one clock later with `res_valid` high; a granted translation returns the frame number and noncacheable bit of the matching slot.
- R2: An entry with its global bit clear matches only when both the page number and the 6-bit address-space tag equal the request.
- R3: An entry with its global bit set matches on page number alone, whatever the request's tag.
- R4: Each response asserts exactly one of `res_hit`, `res_refill`, `res_invalid`, `res_modify`. `res_refill` means that no entry matched.
- R5: A match on a slot whose valid bit is clear gives `res_invalid`.
- R6: A store that matches a valid slot whose dirty (write-enable) bit is clear gives `res_modify`. A load to that same slot gives `res_hit`.
- R7: An indexed write (`wr_en` with `wr_random`=0) stores the entry into the slot held in the index register, which `idx_we` loads from `idx_in`.
- R8: After reset the random counter `rand_o` is N-1. On every clock it decreases by one, and from a value at or below the locked count it goes back to N-1. A locked-count write also sets it to N-1. A random write (`wr_random`=1) goes to the slot shown on `rand_o`, so it never lands below the locked count.
- R9: When several slots match, the lowest-numbered slot supplies the response and `res_multi` is 1; with one match `res_multi` is 0.
- R10: A probe loads the index register with the lowest matching slot and clears `probe_nf_o`. With no match it sets `probe_nf_o` and leaves the index register unchanged. An `idx_we` in the same cycle takes priority over the probe.
- R11: A lookup issued in the same cycle as a write to the slot it would match is judged against the slot's contents before that write.
- R12: After reset every entry is zero, the index register is 0, `probe_nf_o` is 0 and the locked count is 0, so a lookup of any nonzero page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_store | input | 1 | Lookup is a store |
| res_valid | output | 1 | Lookup response present |
| res_hit | output | 1 | Translation granted |
| res_refill | output | 1 | No entry matched |
| res_invalid | output | 1 | Matching entry not valid |
| res_modify | output | 1 | Store to a clean entry |
| res_multi | output | 1 | More than one entry matched |
| res_pfn | output | PFN_W | Frame number of the selected slot |
| res_ncache | output | 1 | Noncacheable bit of the selected slot |
| wr_en | input | 1 | Entry write command |
| wr_random | input | 1 | 1: random slot, 0: indexed slot |
| wr_vpn | input | VPN_W | Written page number |
| wr_asid | input | ASID_W | Written address-space tag |
| wr_global | input | 1 | Written global bit |
| wr_pfn | input | PFN_W | Written frame number |
| wr_valid | input | 1 | Written valid bit |
| wr_dirty | input | 1 | Written dirty (write-enable) bit |
| wr_ncache | input | 1 | Written noncacheable bit |
| idx_we | input | 1 | Load index register |
| idx_in | input | IDX_W | Index register value |
| probe_req | input | 1 | Probe command |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe address-space tag |
| wired_we | input | 1 | Load locked-slot count |
| wired_in | input | IDX_W | Locked-slot count |
| index_o | output | IDX_W | Index register |
| probe_nf_o | output | 1 | Last probe found nothing |
| rand_o | output | IDX_W | Random replacement slot |

## Verification
Two pairs of functions can fall in the same cycle: a lookup with an entry write, and a probe with an index-register load. The bench drives a lookup and an indexed write to the slot that lookup would hit on the same falling edge. The scoreboard expects the answer computed from the entry as it stood before the write, and a later lookup expects the new contents. It also issues a probe together with `idx_we` and expects the index register to hold the loaded value rather than the probed slot.

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_refill,
  output logic              res_invalid,
  output logic              res_modify,
  output logic              res_multi,
  output logic [PFN_W-1:0]  res_pfn,
  output logic              res_ncache,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic              wr_ncache,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              probe_req,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  input  logic              wired_we,
  input  logic [IDX_W-1:0]  wired_in,
  output logic [IDX_W-1:0]  index_o,
  output logic              probe_nf_o,
  output logic [IDX_W-1:0]  rand_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N - 1);

  logic [VPN_W-1:0]  e_vpn  [N];
  logic [ASID_W-1:0] e_asid [N];
  logic [PFN_W-1:0]  e_pfn  [N];
  logic [N-1:0]      e_g, e_v, e_d, e_nc;

  logic [N-1:0]     lk_m, pr_m;
  logic [IDX_W-1:0] lk_sel, pr_sel, wr_slot;
  logic [IDX_W-1:0] idx_q, rand_q, wired_q;
  logic             nf_q;

  function automatic logic [IDX_W-1:0] first_of(input logic [N-1:0] m);
    first_of = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m[i]) first_of = IDX_W'(i);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lk_m[i] = (e_vpn[i] == lk_vpn) && (e_g[i] || e_asid[i] == lk_asid);
      pr_m[i] = (e_vpn[i] == pr_vpn) && (e_g[i] || e_asid[i] == pr_asid);
    end
  end

  assign lk_sel  = first_of(lk_m);
  assign pr_sel  = first_of(pr_m);
  assign wr_slot = wr_random ? rand_q : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_vpn[i]  <= '0;
        e_asid[i] <= '0;
        e_pfn[i]  <= '0;
      end
      e_g <= '0; e_v <= '0; e_d <= '0; e_nc <= '0;
    end else if (wr_en) begin
      e_vpn[wr_slot]  <= wr_vpn;
      e_asid[wr_slot] <= wr_asid;
      e_pfn[wr_slot]  <= wr_pfn;
      e_g[wr_slot]    <= wr_global;
      e_v[wr_slot]    <= wr_valid;
      e_d[wr_slot]    <= wr_dirty;
      e_nc[wr_slot]   <= wr_ncache;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rand_q  <= TOP;
      wired_q <= '0;
    end else if (wired_we) begin
      rand_q  <= TOP;
      wired_q <= wired_in;
    end else begin
      rand_q <= (rand_q <= wired_q) ? TOP : rand_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      nf_q  <= 1'b0;
    end else if (idx_we) begin
      idx_q <= idx_in;
    end else if (probe_req) begin
      nf_q <= ~|pr_m;
      if (|pr_m) idx_q <= pr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_refill  <= 1'b0;
      res_invalid <= 1'b0;
      res_modify  <= 1'b0;
      res_multi   <= 1'b0;
      res_pfn     <= '0;
      res_ncache  <= 1'b0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) begin
        res_refill  <= ~|lk_m;
        res_invalid <= |lk_m && !e_v[lk_sel];
        res_modify  <= |lk_m && e_v[lk_sel] && lk_store && !e_d[lk_sel];
        res_hit     <= |lk_m && e_v[lk_sel] && !(lk_store && !e_d[lk_sel]);
        res_multi   <= (lk_m & (lk_m - 1'b1)) != '0;
        res_pfn     <= |lk_m ? e_pfn[lk_sel] : '0;
        res_ncache  <= |lk_m && e_nc[lk_sel];
      end
    end
  end

  assign index_o    = idx_q;
  assign probe_nf_o = nf_q;
  assign rand_o     = rand_q;

  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_refill, res_invalid, res_modify}));

  p_multi_not_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_multi |-> !res_refill);

  p_rand_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rand_q >= wired_q || rand_q == TOP);

  p_rand_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wired_we && rand_q > wired_q |=> rand_q == $past(rand_q) - 1'b1);

  p_probe_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req && !idx_we && pr_m == '0 |=> nf_q && $stable(idx_q));
endmodule

// File: tb/tb_sw_tlb.sv
module tb_sw_tlb;
  localparam int N = 8, VPN_W = 20, PFN_W = 20, ASID_W = 6, IDX_W = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic lk_req = 0, lk_store = 0;
  logic [VPN_W-1:0] lk_vpn = 0, wr_vpn = 0, pr_vpn = 0;
  logic [ASID_W-1:0] lk_asid = 0, wr_asid = 0, pr_asid = 0;
  logic res_valid, res_hit, res_refill, res_invalid, res_modify, res_multi, res_ncache;
  logic [PFN_W-1:0] res_pfn, wr_pfn = 0;
  logic wr_en = 0, wr_random = 0, wr_global = 0, wr_valid = 0, wr_dirty = 0, wr_ncache = 0;
  logic idx_we = 0, probe_req = 0, wired_we = 0;
  logic [IDX_W-1:0] idx_in = 0, wired_in = 0, index_o, rand_o;
  logic probe_nf_o;

  sw_tlb dut (.*);

  typedef struct packed {
    logic hit, refill, inval, modify, multi;
    logic [PFN_W-1:0] pfn;
    logic nc;
  } res_t;
  typedef struct { res_t r; string tag; } item_t;

  item_t q[$];
  int checks = 0, errors = 0;

  logic [VPN_W-1:0]  m_vpn [N];
  logic [ASID_W-1:0] m_asid[N];
  logic [PFN_W-1:0]  m_pfn [N];
  logic [N-1:0] m_g = 0, m_v = 0, m_d = 0, m_nc = 0;
  initial for (int i = 0; i < N; i++) begin m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic res_t model(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic st);
    res_t r; int first = -1, cnt = 0;
    for (int i = 0; i < N; i++)
      if (m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) begin
        cnt++;
        if (first < 0) first = i;
      end
    r = '0;
    if (first < 0) r.refill = 1;
    else begin
      r.pfn = m_pfn[first];
      r.nc = m_nc[first];
      r.multi = cnt > 1;
      if (!m_v[first]) r.inval = 1;
      else if (st && !m_d[first]) r.modify = 1;
      else r.hit = 1;
    end
    return r;
  endfunction

  // Drive stimulus on the falling edge; the design samples at the next rising edge.
  task automatic push_lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                             input logic st, input string tag);
    item_t it;
    lk_req = 1; lk_vpn = v; lk_asid = a; lk_store = st;
    it.r = model(v, a, st); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_write(input bit rnd, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                           input logic g, input logic [PFN_W-1:0] p, input logic vl,
                           input logic d, input logic nc);
    int s;
    s = rnd ? int'(rand_o) : int'(index_o);
    wr_en = 1; wr_random = rnd; wr_vpn = v; wr_asid = a; wr_global = g;
    wr_pfn = p; wr_valid = vl; wr_dirty = d; wr_ncache = nc;
    m_vpn[s] = v; m_asid[s] = a; m_pfn[s] = p; m_g[s] = g; m_v[s] = vl; m_d[s] = d; m_nc[s] = nc;
  endtask

  task automatic idle;
    @(negedge clk);
    lk_req = 0; wr_en = 0; idx_we = 0; probe_req = 0; wired_we = 0;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input logic st, input string tag);
    push_lookup(v, a, st, tag); idle;
  endtask

  task automatic write_at(input int slot, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                          input logic g, input logic [PFN_W-1:0] p, input logic vl,
                          input logic d, input logic nc);
    idx_we = 1; idx_in = IDX_W'(slot); idle;
    set_write(0, v, a, g, p, vl, d, nc); idle;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      res_t act; item_t e;
      act = '{res_hit, res_refill, res_invalid, res_modify, res_multi, res_pfn, res_ncache};
      if (q.size() == 0) check(0, "R1 unexpected response", longint'(act), 0);
      else begin
        e = q.pop_front();
        check(act == e.r, e.tag, longint'(act), longint'(e.r));
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run;
  end

  initial begin
    logic [IDX_W-1:0] prev, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(index_o == 0, "R12 index reset", index_o, 0);
    check(probe_nf_o == 0, "R12 nf reset", probe_nf_o, 0);
    lookup(20'h123, 1, 0, "R12 R4 empty miss");

    write_at(1, 20'h100, 3, 0, 20'hAAAAA, 1, 1, 1);
    lookup(20'h100, 3, 0, "R1 R7 indexed hit");
    lookup(20'h100, 4, 0, "R2 asid mismatch");
    write_at(2, 20'h200, 5, 1, 20'h00022, 1, 1, 0);
    lookup(20'h200, 9, 0, "R3 global any asid");
    write_at(3, 20'h300, 7, 0, 20'h00033, 0, 1, 0);
    lookup(20'h300, 7, 0, "R5 invalid entry");
    write_at(4, 20'h400, 0, 0, 20'h00044, 1, 0, 0);
    lookup(20'h400, 0, 0, "R6 load clean hit");
    lookup(20'h400, 0, 1, "R6 store clean modify");
    lookup(20'h100, 3, 1, "R6 store dirty hit");
    write_at(5, 20'h100, 3, 0, 20'h00055, 1, 1, 0);
    lookup(20'h100, 3, 0, "R9 multi lowest slot");

    probe_req = 1; pr_vpn = 20'h400; pr_asid = 0; idle;
    check(index_o == 4 && !probe_nf_o, "R10 probe found", index_o, 4);
    probe_req = 1; pr_vpn = 20'h999; idle;
    check(index_o == 4 && probe_nf_o, "R10 probe miss", {probe_nf_o, index_o}, 12);
    probe_req = 1; pr_vpn = 20'h400; idx_we = 1; idx_in = 6; idle;
    check(index_o == 6, "R10 idx load over probe", index_o, 6);

    // Same cycle lookup and write to slot 1
    idx_we = 1; idx_in = 1; idle;
    push_lookup(20'h100, 3, 0, "R11 old contents");
    set_write(0, 20'h700, 3, 0, 20'h00077, 1, 1, 0); idle;
    lookup(20'h700, 3, 0, "R11 new contents");
    lookup(20'h100, 3, 0, "R11 remaining slot");

    wired_we = 1; wired_in = 3; idle;
    check(rand_o == 7, "R8 rand top after wired", rand_o, 7);
    prev = rand_o;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      exp = (prev <= 3) ? 3'd7 : prev - 3'd1;
      check(rand_o == exp, "R8 rand step", rand_o, exp);
      prev = rand_o;
    end
    for (int k = 0; k < 6; k++) begin
      check(rand_o >= 3, "R8 random slot not locked", rand_o, 3);
      set_write(1, 20'h800 + 20'(k), 2, 0, 20'h00080 + 20'(k), 1, 1, 0); idle;
    end
    for (int k = 0; k < 6; k++) lookup(20'h800 + 20'(k), 2, 0, "R8 random write lookup");
    lookup(20'h200, 1, 0, "R3 locked global kept");
    lookup(20'h100, 3, 0, "R9 after random writes");
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R1 responses drained", q.size(), 0);
    finish_run;
  end
endmodule